// File: doc/BRIEF.md
# SPI Configuration Port Slave

This block is the device end of a serial configuration link. A controller selects the device by pulling an active-low chip select, then clocks a 16-bit instruction header followed by data bytes. All traffic uses one bidirectional data line. The header is sent most significant bit first. It holds a direction flag, a two-bit length code and a 13-bit register address. On a write, each byte received is handed to a parallel register bus as a one-cycle strobe. On a read, bytes taken from that bus are shifted back out on the same line, which the block drives only while a read is under way. When the `SDO_EN` parameter is set, the read data is also copied to a separate output, which has its own enable.

The pin inputs are asynchronous to the block clock. They pass through a synchronizer, and the serial clock edges are then detected in the block clock domain. The system clock must therefore run several times faster than the serial clock. Every pin output is shown as a value plus an output enable, and the pad ring performs the actual tri-stating. The controller is always mode 0: the serial clock idles low, input bits are taken on rising edges and read bits are launched on falling edges.

The sequencer has five states:
- `ST_IDLE`: chip select is high.
- `ST_INSTR`: the header is being collected.
- `ST_WRITE`: write data phase.
- `ST_READ`: read data phase.
- `ST_DONE`: the length is used up and the block waits for deselect.

Transitions:
- `ST_IDLE`→`ST_INSTR` when select goes low.
- `ST_INSTR`→`ST_WRITE` or `ST_READ` on the 16th rising edge, chosen by the direction flag.
- `ST_WRITE`/`ST_READ`→`ST_DONE` on the last rising edge of the final byte of a bounded transfer.
- Any state→`ST_IDLE` whenever select is high.

Top module: `cfgport_slave`

## Requirements
- R1: After reset, `sdio_oe`, `sdo_oe` and `reg_we` are 0 and `reg_addr` is 0.
- R2: The header is taken on serial clock rising edges, most significant bit first. Header bit 15 is the direction (0 write, 1 read). Bits 14:13 are the length code. Bits 12:0 are the start address.
- R3: In a write, each completed data byte (first bit received = bit 7) gives exactly one single-cycle `reg_we` pulse. During that pulse, `reg_wdata` holds the byte and `reg_addr` holds the byte's address.
- R4: The length code sets the byte count: 00 means one byte, 01 two bytes, 10 three bytes. Serial clock edges after the last byte, up to deselect, cause no strobe and no drive.
- R5: Length code 11 streams bytes without limit until chip select rises.
- R6: The address steps up by one after every data byte and wraps from 0x1FFF to 0x0000.
- R7: In a read, the byte at `reg_rdata` for the current address is sent most significant bit first. Each bit is launched on a serial clock falling edge. The first bit is launched on the falling edge that follows the 16th rising edge.
- R8: `sdio_oe` is 1 only in the read data phase while bytes remain. It is 0 during the header, during writes, after the last byte and while deselected.
- R9: With `SDO_EN`=1, `sdo_o`/`sdo_oe` follow `sdio_o`/`sdio_oe`. With `SDO_EN`=0, both are held at 0.
- R10: Chip select rising in the middle of a byte discards the partial byte and returns the block to idle. The next frame then works normally.
- R11: If chip select rises in the same synchronized cycle as the rising edge that completes a byte, the byte is discarded and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csb_i | input | 1 | Chip select pin, active low |
| sclk_i | input | 1 | Serial clock pin |
| sdio_i | input | 1 | Data line, input side |
| sdio_o | output | 1 | Data line, output value |
| sdio_oe | output | 1 | Data line drive enable |
| sdo_o | output | 1 | Separate read-data output value |
| sdo_oe | output | 1 | Separate read-data output enable |
| reg_addr | output | ADDR_W | Register bus address |
| reg_wdata | output | DATA_W | Register bus write data |
| reg_we | output | 1 | Register bus write strobe |
| reg_rdata | input | DATA_W | Register bus read data for `reg_addr` |

## Verification
Two events can land in the same block clock cycle:
- the rising edge that completes a byte, which issues a write strobe;
- the deselect, which aborts the frame.

The bench provokes this by changing the chip select and the serial clock in the same instant. Both pins then pass through the same synchronizer, so their edges arrive in one cycle. The abort must win. This is judged in two ways: no strobe may appear, and a later read of that address must still return the old contents.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INSTR = 3'd1,
        ST_WRITE = 3'd2,
        ST_READ  = 3'd3,
        ST_DONE  = 3'd4
    } cfg_state_e;

    typedef enum logic [1:0] {
        WL_ONE    = 2'b00,
        WL_TWO    = 2'b01,
        WL_THREE  = 2'b10,
        WL_STREAM = 2'b11
    } wlen_e;

endpackage

// File: rtl/cfgport_sync.sv
module cfgport_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= RST_VAL;
                else        stg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= {STAGES{RST_VAL}};
                else        stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/cfgport_edge.sv
module cfgport_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic lvl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign rise = lvl & ~lvl_d;
    assign fall = ~lvl & lvl_d;

endmodule

// File: rtl/cfgport_txsh.sv
module cfgport_txsh #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              shift_evt,
    input  logic [DATA_W-1:0] load_val,
    output logic              bit_o
);

    localparam int IDX_W = $clog2(DATA_W);

    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-2:0] rest_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            rest_q <= '0;
            bit_o  <= 1'b0;
        end else if (!active) begin
            idx_q <= '0;
        end else if (shift_evt) begin
            if (idx_q == '0) {bit_o, rest_q} <= load_val;
            else             {bit_o, rest_q} <= {rest_q, 1'b0};
            idx_q <= (idx_q == IDX_W'(DATA_W-1)) ? '0 : idx_q + 1'b1;
        end
    end

    // R7
    tx_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> idx_q == '0);

endmodule

// File: rtl/cfgport_slave.sv
module cfgport_slave
    import spi_cfg_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit SDO_EN      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csb_i,
    input  logic              sclk_i,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              sdo_o,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int HDR_W = ADDR_W + 3;
    localparam int CNT_W = $clog2(HDR_W);

    // synchronized pins and serial clock edges
    logic [2:0] pin_sync;
    logic       csb_s, sclk_s, sdio_s;
    logic       sclk_rise, sclk_fall;

    cfgport_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({csb_i, sclk_i, sdio_i}),
        .q    (pin_sync)
    );

    assign {csb_s, sclk_s, sdio_s} = pin_sync;

    cfgport_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sclk_s),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    // state and datapath registers
    cfg_state_e        state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [1:0]        byte_cnt_q;
    logic [HDR_W-2:0]  hdr_sr_q;
    logic [DATA_W-2:0] dat_sr_q;
    wlen_e             wlen_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;
    logic              oe_q;

    logic [HDR_W-1:0]  hdr_full;
    logic              hdr_last, byte_last, final_byte;

    assign hdr_full   = {hdr_sr_q, sdio_s};
    assign hdr_last   = sclk_rise && (bit_cnt_q == CNT_W'(HDR_W-1));
    assign byte_last  = sclk_rise && (bit_cnt_q == CNT_W'(DATA_W-1));
    assign final_byte = (wlen_q != WL_STREAM) && (byte_cnt_q == 2'(wlen_q));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (csb_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_INSTR;
                ST_INSTR: if (hdr_last)
                              state_d = hdr_full[HDR_W-1] ? ST_READ : ST_WRITE;
                ST_WRITE: if (byte_last && final_byte) state_d = ST_DONE;
                ST_READ:  if (byte_last && final_byte) state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            byte_cnt_q <= '0;
            hdr_sr_q   <= '0;
            dat_sr_q   <= '0;
            wlen_q     <= WL_ONE;
            addr_q     <= '0;
            wdata_q    <= '0;
            we_q       <= 1'b0;
            oe_q       <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (we_q) addr_q <= addr_q + 1'b1;
            if (csb_s) begin
                bit_cnt_q  <= '0;
                byte_cnt_q <= '0;
                oe_q       <= 1'b0;
            end else if (sclk_rise) begin
                unique case (state_q)
                    ST_IDLE, ST_INSTR: begin
                        hdr_sr_q <= hdr_full[HDR_W-2:0];
                        if (hdr_last) begin
                            bit_cnt_q  <= '0;
                            byte_cnt_q <= '0;
                            wlen_q     <= wlen_e'(hdr_full[HDR_W-2 -: 2]);
                            addr_q     <= hdr_full[ADDR_W-1:0];
                            oe_q       <= hdr_full[HDR_W-1];
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                    ST_WRITE: begin
                        dat_sr_q <= {dat_sr_q[DATA_W-3:0], sdio_s};
                        if (byte_last) begin
                            bit_cnt_q  <= '0;
                            byte_cnt_q <= byte_cnt_q + 1'b1;
                            wdata_q    <= {dat_sr_q, sdio_s};
                            we_q       <= 1'b1;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                    ST_READ: begin
                        if (byte_last) begin
                            bit_cnt_q  <= '0;
                            byte_cnt_q <= byte_cnt_q + 1'b1;
                            addr_q     <= addr_q + 1'b1;
                            if (final_byte) oe_q <= 1'b0;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                    ST_DONE: ;
                    default: ;
                endcase
            end
        end
    end

    // read shifter
    logic tx_active, tx_bit;
    assign tx_active = (state_q == ST_READ) && !csb_s;

    cfgport_txsh #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (tx_active),
        .shift_evt(sclk_fall),
        .load_val (reg_rdata),
        .bit_o    (tx_bit)
    );

    assign sdio_o    = tx_bit;
    assign sdio_oe   = oe_q;
    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;

    generate
        if (SDO_EN) begin : g_sdo
            assign sdo_o  = tx_bit;
            assign sdo_oe = oe_q;
        end else begin : g_no_sdo
            assign sdo_o  = 1'b0;
            assign sdo_oe = 1'b0;
        end
    endgenerate

    // R3
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R4
    we_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(state_q) == ST_WRITE);

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> reg_addr == ADDR_W'($past(reg_addr) + 1'b1));

    // R8
    oe_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> state_q == ST_READ);

    // R10
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csb_s |=> !sdio_oe && !reg_we);

endmodule

// File: tb/sim_cfgport_slave.sv
`timescale 1ns/1ps
module sim_cfgport_slave;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csb_i = 1'b1;
    logic       sclk_i = 1'b0;
    logic       sdio_i = 1'b0;
    logic       sdio_o, sdio_oe, sdo_o, sdo_oe;
    logic [12:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_we;
    logic [7:0]  reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  mem [64];
    logic [20:0] exp_wq [$];
    logic [7:0]  wbuf [8];

    always #4 clk = ~clk;

    assign reg_rdata = mem[reg_addr[5:0]];

    cfgport_slave u0 (
        .clk(clk), .rst_n(rst_n), .csb_i(csb_i), .sclk_i(sclk_i), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // per-clock reference: expected write queue and output mirror
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (reg_we) begin
                if (exp_wq.size() == 0) begin
                    chk(1'b0, "R3/R4 unexpected strobe", {reg_addr, reg_wdata}, 0);
                end else begin
                    logic [20:0] e;
                    e = exp_wq.pop_front();
                    chk({reg_addr, reg_wdata} == e, "R3/R6 strobe addr/data",
                        {reg_addr, reg_wdata}, e);
                    mem[e[18:13]] = e[7:0];
                end
            end
            chk(sdo_oe == sdio_oe && (!sdio_oe || sdo_o == sdio_o), "R9 mirror",
                {sdo_oe, sdo_o}, {sdio_oe, sdio_o});
        end
    end

    task automatic step();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame(input bit rw, input logic [1:0] wl, input logic [12:0] a,
                         input int nbits, input bit coincide, input string tag);
        int len;
        logic [15:0] hdr;
        logic [7:0] got [8];
        len = (wl == 2'b11) ? 1000 : int'(wl) + 1;
        hdr = {rw, wl, a};
        if (!rw) begin
            int full = nbits / 8;
            int n = (full < len) ? full : len;
            if (coincide && (nbits % 8 == 0) && full <= len && n > 0) n--;
            for (int k = 0; k < n; k++) exp_wq.push_back({13'(a + 13'(k)), wbuf[k]});
        end
        csb_i = 1'b0;
        step();
        for (int i = 15; i >= 0; i--) begin
            sdio_i = hdr[i];
            step();
            chk(sdio_oe == 1'b0, {tag, " R8 header no drive"}, sdio_oe, 0);
            sclk_i = 1'b1;
            step();
            sclk_i = 1'b0;
        end
        for (int i = 0; i < nbits; i++) begin
            int by = i / 8;
            int bp = 7 - (i % 8);
            bit exp_oe = rw && (by < len);
            if (!rw) sdio_i = wbuf[by][bp];
            step();
            chk(sdio_oe == exp_oe, {tag, " R8/R4 drive enable"}, sdio_oe, exp_oe);
            if (exp_oe) got[by][bp] = sdio_o;
            if (coincide && i == nbits - 1) csb_i = 1'b1;
            sclk_i = 1'b1;
            step();
            sclk_i = 1'b0;
        end
        step();
        csb_i = 1'b1;
        repeat (3) step();
        chk(exp_wq.size() == 0, {tag, " R3/R4 strobes outstanding"}, exp_wq.size(), 0);
        chk(sdio_oe == 1'b0, {tag, " R8 released after deselect"}, sdio_oe, 0);
        if (rw) begin
            for (int b = 0; b < nbits / 8 && b < len; b++) begin
                logic [12:0] ab;
                ab = a + 13'(b);
                chk(got[b] == mem[ab[5:0]], {tag, " R7/R6 read byte"}, got[b], mem[ab[5:0]]);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(sdio_oe == 0 && sdo_oe == 0, "R1 enables", {sdio_oe, sdo_oe}, 0);
        chk(reg_we == 0, "R1 strobe", reg_we, 0);
        chk(reg_addr == 0, "R1 address", reg_addr, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 R3 R4: one-byte write, extra byte ignored
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
        frame(1'b0, 2'b00, 13'h010, 16, 1'b0, "R2 w1");
        // two- and three-byte writes
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        frame(1'b0, 2'b01, 13'h020, 24, 1'b0, "R4 w2");
        wbuf[0] = 8'h44; wbuf[1] = 8'h55; wbuf[2] = 8'h66;
        frame(1'b0, 2'b10, 13'h030, 32, 1'b0, "R4 w3");
        // R5 R6: streaming write across address wrap
        for (int k = 0; k < 5; k++) wbuf[k] = 8'(8'hC0 + k);
        frame(1'b0, 2'b11, 13'h1FFE, 40, 1'b0, "R5 stream");
        // R7: reads
        frame(1'b1, 2'b00, 13'h010, 16, 1'b0, "R7 r1");
        frame(1'b1, 2'b10, 13'h1FFF, 32, 1'b0, "R6 r3 wrap");
        frame(1'b1, 2'b11, 13'h02E, 32, 1'b0, "R5 rstream");
        // R10: abort mid-byte, then normal frames
        wbuf[0] = 8'h9E; wbuf[1] = 8'h77;
        frame(1'b0, 2'b11, 13'h008, 12, 1'b0, "R10 abort");
        frame(1'b1, 2'b01, 13'h008, 16, 1'b0, "R10 readback");
        wbuf[0] = 8'h5A;
        frame(1'b0, 2'b00, 13'h00C, 8, 1'b0, "R10 recover");
        // R11: deselect coincides with completing edge
        wbuf[0] = 8'hFF;
        frame(1'b0, 2'b00, 13'h00D, 8, 1'b1, "R11 coincide");
        frame(1'b1, 2'b00, 13'h00D, 8, 1'b0, "R11 readback");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule